// File: doc/BRIEF.md
# Branch Sequencer with Delay Slots

This block decides the program counter that follows each instruction of a small processor with 16-bit instruction alignment. For every instruction presented on its input stream it returns the next PC, whether control was redirected, and the value held in its single return-address (link) register. It tests the N, Z, V and C flags against a condition code for conditional jumps. It forms PC-relative targets from a signed displacement or from a register offset, and absolute targets from a small immediate or from a register. Calls save a return address and returns go back to it.

Any jump, call or return can be marked delayed. A delayed transfer that is taken first lets the next sequential instruction (the slot) run, and control moves when that slot instruction is consumed. A conditional branch that is not taken advances sequentially and leaves no delay pending. A branch that arrives in a slot is an illegal sequence: it is ignored, an error pulse is raised, and the pending transfer still completes.

The input side uses valid/ready. `in_ready` is low while reset is asserted and during the first cycle after reset, and high from then on. An instruction is consumed on a clock edge where `in_valid` and `in_ready` are both high. The result side has no back-pressure: `out_valid` pulses for one cycle per consumed instruction, and the consumer must take it.

Top module: `branch_seq_unit`

## Requirements
- R1: Opcodes are 0 none, 1 relative jump, 2 absolute jump, 3 conditional jump, 4 relative call, 5 absolute call, 6 return, 7 treated as none. A non-branch instruction with no delay pending gives next PC = in_pc + 2 with out_taken low.
- R2: Flags are in_flags[3]=N, [2]=Z, [1]=V, [0]=C. The signed conditions are code 0 greater (!Z & !(N^V)), 1 greater-or-equal (!(N^V)), 2 less (N^V) and 3 less-or-equal (Z | (N^V)).
- R3: The unsigned conditions are code 4 higher (!Z & !C), 5 higher-or-same (!C), 6 lower (C) and 7 lower-or-same (Z | C). Code 8 tests Z set, code 9 tests Z clear, and codes 10 to 15 never branch. A conditional jump that is not taken gives in_pc + 2 with out_taken low.
- R4: A conditional jump targets in_pc + 2 + 2·sext(in_disp[6:0]). Relative jumps and relative calls target in_pc + 2 + 2·sext(in_disp[9:0]). When in_use_reg is high they target in_pc + 2 + in_reg instead, with in_reg taken as a byte offset. in_use_reg has no effect on conditional jumps.
- R5: Absolute jumps and calls target 2·in_disp[6:0], zero-extended. When in_use_reg is high they target in_reg with bit 0 cleared.
- R6: A call writes the link register with in_pc + 2, or with in_pc + 4 when it is delayed. The new value shows on out_link together with the call's result.
- R7: A return targets the link register value held when the return is consumed.
- R8: A taken transfer with in_delay high returns in_pc + 2 with out_taken low. The next consumed instruction then returns the saved target with out_taken high. A delayed conditional jump that is not taken enters no delay.
- R9: A branch consumed while a delay is pending is ignored: the link register is left unchanged and no new delay starts. Its result carries the pending target with out_taken and out_err both high. out_err is otherwise low.
- R10: Each consumed instruction yields exactly one result, with out_valid high on the cycle after the consuming edge. Idle cycles give no result and keep any pending delay.
- R11: Reset clears the outputs, the link register and any pending delay, and holds in_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block accepts an instruction |
| in_pc | input | PC_W | Address of the instruction |
| in_op | input | 3 | Branch opcode |
| in_delay | input | 1 | Delayed variant |
| in_use_reg | input | 1 | Take the register operand instead of the immediate |
| in_cond | input | 4 | Condition code for conditional jumps |
| in_disp | input | DISP_W | Signed displacement or absolute immediate |
| in_reg | input | PC_W | Register operand |
| in_flags | input | 4 | N, Z, V, C flags |
| out_valid | output | 1 | Result strobe |
| out_pc | output | PC_W | Next PC |
| out_taken | output | 1 | Control redirected on this result |
| out_link | output | PC_W | Link register contents |
| out_err | output | 1 | Branch seen in a delay slot |

## Verification
Every result comes from one register stage, so next PC, taken, error and the link value all appear on the cycle after the consuming edge. The bench drives each instruction at a falling edge and samples all four one time step after the following rising edge. Delayed transfers span two consumed instructions, so the vector table lists slot instructions right after their branches and checks the redirect on the slot's own result. An idle cycle is placed between a delayed branch and its slot to show that the pending target waits.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_JREL  = 3'd1,
    OP_JABS  = 3'd2,
    OP_JCOND = 3'd3,
    OP_CREL  = 3'd4,
    OP_CABS  = 3'd5,
    OP_RET   = 3'd6,
    OP_RSVD  = 3'd7
  } bsu_op_e;

  typedef enum logic [3:0] {
    CC_GT  = 4'd0,
    CC_GE  = 4'd1,
    CC_LT  = 4'd2,
    CC_LE  = 4'd3,
    CC_HI  = 4'd4,
    CC_HS  = 4'd5,
    CC_LO  = 4'd6,
    CC_LS  = 4'd7,
    CC_EQ  = 4'd8,
    CC_NE  = 4'd9
  } bsu_cc_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

  function automatic logic op_is_branch(input logic [2:0] op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

  function automatic logic op_is_call(input logic [2:0] op);
    return (op == OP_CREL) || (op == OP_CABS);
  endfunction
endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval
  import bsu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       hit
);
  logic n_f, z_f, v_f, c_f, lt_s;

  assign n_f  = flags[FLG_N];
  assign z_f  = flags[FLG_Z];
  assign v_f  = flags[FLG_V];
  assign c_f  = flags[FLG_C];
  assign lt_s = n_f ^ v_f;

  always_comb begin
    unique case (cond)
      CC_GT:   hit = !z_f && !lt_s;
      CC_GE:   hit = !lt_s;
      CC_LT:   hit = lt_s;
      CC_LE:   hit = z_f || lt_s;
      CC_HI:   hit = !z_f && !c_f;
      CC_HS:   hit = !c_f;
      CC_LO:   hit = c_f;
      CC_LS:   hit = z_f || c_f;
      CC_EQ:   hit = z_f;
      CC_NE:   hit = !z_f;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsu_target_calc.sv
module bsu_target_calc
  import bsu_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int DISP_W       = 10,
  parameter int CDISP_W      = 7,
  parameter int ABS_W        = 7,
  parameter bit ABS_HALFWORD = 1'b1
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [2:0]        op,
  input  logic              use_reg,
  input  logic              delay,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   rg,
  input  logic [PC_W-1:0]   link,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   link_next
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

  logic [PC_W-1:0] long_off, short_off, rel_off, abs_imm, abs_tgt;

  assign seq_pc    = pc + INSN_BYTES;
  assign link_next = delay ? (seq_pc + INSN_BYTES) : seq_pc;

  assign long_off  = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp} << 1;
  assign short_off = {{(PC_W-CDISP_W){disp[CDISP_W-1]}}, disp[CDISP_W-1:0]} << 1;

  generate
    if (ABS_HALFWORD) begin : g_abs_half
      assign abs_imm = {{(PC_W-ABS_W-1){1'b0}}, disp[ABS_W-1:0], 1'b0};
    end else begin : g_abs_byte
      assign abs_imm = {{(PC_W-ABS_W){1'b0}}, disp[ABS_W-1:0]};
    end
  endgenerate

  assign abs_tgt = use_reg ? {rg[PC_W-1:1], 1'b0} : abs_imm;

  always_comb begin
    if (op == OP_JCOND) rel_off = short_off;
    else if (use_reg)   rel_off = rg;
    else                rel_off = long_off;
  end

  always_comb begin
    case (op)
      OP_JREL, OP_JCOND, OP_CREL: target = seq_pc + rel_off;
      OP_JABS, OP_CABS:           target = abs_tgt;
      OP_RET:                     target = link;
      default:                    target = seq_pc;
    endcase
  end
endmodule

// File: rtl/bsu_seq_ctrl.sv
module bsu_seq_ctrl
  import bsu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      op,
  input  logic            delay,
  input  logic            cond_hit,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] link_next,
  output logic [PC_W-1:0] link,
  output logic            pend,
  output logic            out_valid,
  output logic [PC_W-1:0] out_pc,
  output logic            out_taken,
  output logic            out_err
);
  logic            ready_q, pend_q;
  logic [PC_W-1:0] pend_tgt_q, link_q;
  logic            accept, is_br, wants;
  logic [PC_W-1:0] nxt_pc;
  logic            nxt_taken, nxt_err, nxt_pend, wr_link;
  logic [PC_W-1:0] nxt_pend_tgt;

  assign accept   = in_valid && ready_q;
  assign is_br    = op_is_branch(op);
  assign wants    = is_br && ((op != OP_JCOND) || cond_hit);
  assign in_ready = ready_q;
  assign link     = link_q;
  assign pend     = pend_q;

  always_comb begin
    nxt_pc       = seq_pc;
    nxt_taken    = 1'b0;
    nxt_err      = 1'b0;
    nxt_pend     = 1'b0;
    nxt_pend_tgt = pend_tgt_q;
    wr_link      = 1'b0;
    if (pend_q) begin
      nxt_pc    = pend_tgt_q;
      nxt_taken = 1'b1;
      nxt_err   = is_br;
    end else if (wants && delay) begin
      nxt_pend     = 1'b1;
      nxt_pend_tgt = target;
      wr_link      = op_is_call(op);
    end else if (wants) begin
      nxt_pc    = target;
      nxt_taken = 1'b1;
      wr_link   = op_is_call(op);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
      link_q     <= '0;
      out_valid  <= 1'b0;
      out_pc     <= '0;
      out_taken  <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept;
      if (accept) begin
        pend_q     <= nxt_pend;
        pend_tgt_q <= nxt_pend_tgt;
        out_pc     <= nxt_pc;
        out_taken  <= nxt_taken;
        out_err    <= nxt_err;
        if (wr_link) link_q <= link_next;
      end else begin
        out_taken <= 1'b0;
        out_err   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/branch_seq_unit.sv
module branch_seq_unit
  import bsu_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int DISP_W       = 10,
  parameter int CDISP_W      = 7,
  parameter int ABS_W        = 7,
  parameter bit ABS_HALFWORD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [2:0]        in_op,
  input  logic              in_delay,
  input  logic              in_use_reg,
  input  logic [3:0]        in_cond,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [PC_W-1:0]   in_reg,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_pc,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_link,
  output logic              out_err
);
  logic            cond_hit, pend_active;
  logic [PC_W-1:0] seq_pc, target, link_next, link_val;

  bsu_cond_eval u_cond (
    .cond  (in_cond),
    .flags (in_flags),
    .hit   (cond_hit)
  );

  bsu_target_calc #(
    .PC_W(PC_W), .DISP_W(DISP_W), .CDISP_W(CDISP_W),
    .ABS_W(ABS_W), .ABS_HALFWORD(ABS_HALFWORD)
  ) u_tgt (
    .pc        (in_pc),
    .op        (in_op),
    .use_reg   (in_use_reg),
    .delay     (in_delay),
    .disp      (in_disp),
    .rg        (in_reg),
    .link      (link_val),
    .seq_pc    (seq_pc),
    .target    (target),
    .link_next (link_next)
  );

  bsu_seq_ctrl #(.PC_W(PC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (in_op),
    .delay     (in_delay),
    .cond_hit  (cond_hit),
    .seq_pc    (seq_pc),
    .target    (target),
    .link_next (link_next),
    .link      (link_val),
    .pend      (pend_active),
    .out_valid (out_valid),
    .out_pc    (out_pc),
    .out_taken (out_taken),
    .out_err   (out_err)
  );

  assign out_link = link_val;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
  import bsu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [PC_W-1:0] in_pc,
  input logic [2:0]      in_op,
  input logic            in_delay,
  input logic            pend,
  input logic            out_valid,
  input logic [PC_W-1:0] out_pc,
  input logic            out_taken,
  input logic [PC_W-1:0] out_link,
  input logic            out_err
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid);

  assert_seq_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_NONE && !pend) |=>
      (out_pc == $past(in_pc) + PC_W'(2)) && !out_taken);

  assert_ret_to_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_RET && !in_delay && !pend) |=>
      (out_pc == $past(out_link)) && out_taken);

  assert_call_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_is_call(in_op) && !pend) |=>
      out_link == ($past(in_pc) + ($past(in_delay) ? PC_W'(4) : PC_W'(2))));

  assert_slot_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pend) |=> out_taken);

  assert_err_with_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_taken));

  assert_slot_link_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pend) |=> $stable(out_link));
endmodule

bind branch_seq_unit bsu_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_pc     (in_pc),
  .in_op     (in_op),
  .in_delay  (in_delay),
  .pend      (pend_active),
  .out_valid (out_valid),
  .out_pc    (out_pc),
  .out_taken (out_taken),
  .out_link  (out_link),
  .out_err   (out_err)
);

// File: tb/branch_seq_unit_bench.sv
module branch_seq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 25;

  typedef struct packed {
    logic [2:0]  op;
    logic        dly;
    logic        ureg;
    logic [3:0]  cond;
    logic [9:0]  disp;
    logic [3:0]  flg;
    logic [15:0] pc;
    logic [15:0] rg;
    logic [15:0] epc;
    logic        etk;
    logic        eer;
  } vec_t;

  // Field order: op, delay, use_reg, cond, disp, flags{N,Z,V,C}, pc, reg, exp_pc, exp_taken, exp_err
  localparam vec_t TBL [NVEC] = '{
    '{3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'b0000, 16'h0100, 16'h0000, 16'h0102, 1'b0, 1'b0}, // R1
    '{3'd1, 1'b0, 1'b0, 4'd0, 10'h005, 4'b0000, 16'h0102, 16'h0000, 16'h010E, 1'b1, 1'b0}, // R4
    '{3'd1, 1'b0, 1'b0, 4'd0, 10'h3FD, 4'b0000, 16'h0200, 16'h0000, 16'h01FC, 1'b1, 1'b0}, // R4
    '{3'd3, 1'b0, 1'b0, 4'd0, 10'h004, 4'b0000, 16'h0300, 16'h0000, 16'h030A, 1'b1, 1'b0}, // R2 GT
    '{3'd3, 1'b0, 1'b0, 4'd0, 10'h004, 4'b0100, 16'h0300, 16'h0000, 16'h0302, 1'b0, 1'b0}, // R2 GT nt
    '{3'd3, 1'b0, 1'b0, 4'd2, 10'h07F, 4'b1000, 16'h0400, 16'h0000, 16'h0400, 1'b1, 1'b0}, // R2 LT
    '{3'd3, 1'b0, 1'b0, 4'd3, 10'h07F, 4'b1010, 16'h0400, 16'h0000, 16'h0402, 1'b0, 1'b0}, // R2 LE nt
    '{3'd3, 1'b0, 1'b0, 4'd4, 10'h002, 4'b0001, 16'h0500, 16'h0000, 16'h0502, 1'b0, 1'b0}, // R3 HI nt
    '{3'd3, 1'b0, 1'b0, 4'd7, 10'h002, 4'b0001, 16'h0500, 16'h0000, 16'h0506, 1'b1, 1'b0}, // R3 LS
    '{3'd3, 1'b0, 1'b0, 4'd8, 10'h001, 4'b0100, 16'h0600, 16'h0000, 16'h0604, 1'b1, 1'b0}, // R3 EQ
    '{3'd3, 1'b0, 1'b0, 4'd9, 10'h001, 4'b0100, 16'h0600, 16'h0000, 16'h0602, 1'b0, 1'b0}, // R3 NE nt
    '{3'd3, 1'b0, 1'b0, 4'd1, 10'h003, 4'b1010, 16'h0700, 16'h0000, 16'h0708, 1'b1, 1'b0}, // R2 GE
    '{3'd3, 1'b0, 1'b0, 4'd5, 10'h000, 4'b0000, 16'h0800, 16'h0000, 16'h0802, 1'b1, 1'b0}, // R3 HS
    '{3'd3, 1'b0, 1'b0, 4'd6, 10'h000, 4'b0000, 16'h0800, 16'h0000, 16'h0802, 1'b0, 1'b0}, // R3 LO nt
    '{3'd3, 1'b0, 1'b0, 4'd15,10'h005, 4'b1111, 16'h0800, 16'h0000, 16'h0802, 1'b0, 1'b0}, // R3 never
    '{3'd2, 1'b0, 1'b0, 4'd0, 10'h010, 4'b0000, 16'h0900, 16'h0000, 16'h0020, 1'b1, 1'b0}, // R5 imm
    '{3'd2, 1'b0, 1'b1, 4'd0, 10'h010, 4'b0000, 16'h0900, 16'h1235, 16'h1234, 1'b1, 1'b0}, // R5 reg
    '{3'd1, 1'b0, 1'b1, 4'd0, 10'h3FF, 4'b0000, 16'h0A00, 16'h0010, 16'h0A12, 1'b1, 1'b0}, // R4 reg
    '{3'd1, 1'b1, 1'b0, 4'd0, 10'h004, 4'b0000, 16'h0B00, 16'h0000, 16'h0B02, 1'b0, 1'b0}, // R8 delayed
    '{3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'b0000, 16'h0B02, 16'h0000, 16'h0B0A, 1'b1, 1'b0}, // R8 slot
    '{3'd3, 1'b1, 1'b0, 4'd8, 10'h004, 4'b0000, 16'h0C00, 16'h0000, 16'h0C02, 1'b0, 1'b0}, // R8 nt delayed
    '{3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'b0000, 16'h0C02, 16'h0000, 16'h0C04, 1'b0, 1'b0}, // R8 no delay
    '{3'd2, 1'b1, 1'b0, 4'd0, 10'h008, 4'b0000, 16'h0D00, 16'h0000, 16'h0D02, 1'b0, 1'b0}, // R8 delayed abs
    '{3'd1, 1'b0, 1'b0, 4'd0, 10'h005, 4'b0000, 16'h0D02, 16'h0000, 16'h0010, 1'b1, 1'b1}, // R9 branch in slot
    '{3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'b0000, 16'h0010, 16'h0000, 16'h0012, 1'b0, 1'b0}  // R9 after
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pc = '0;
  logic [2:0]  in_op = '0;
  logic        in_delay = 1'b0;
  logic        in_use_reg = 1'b0;
  logic [3:0]  in_cond = '0;
  logic [9:0]  in_disp = '0;
  logic [15:0] in_reg = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic [15:0] out_pc;
  logic        out_taken;
  logic [15:0] out_link;
  logic        out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_seq_unit u_branch_seq_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_op(in_op), .in_delay(in_delay), .in_use_reg(in_use_reg),
    .in_cond(in_cond), .in_disp(in_disp), .in_reg(in_reg), .in_flags(in_flags),
    .out_valid(out_valid), .out_pc(out_pc), .out_taken(out_taken),
    .out_link(out_link), .out_err(out_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic dly, input logic ureg,
                       input logic [3:0] cond, input logic [9:0] disp,
                       input logic [3:0] flg, input logic [15:0] pc,
                       input logic [15:0] rg);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_delay = dly; in_use_reg = ureg;
    in_cond = cond; in_disp = disp; in_flags = flg; in_pc = pc; in_reg = rg;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic result(input string req, input logic [15:0] epc,
                        input logic etk, input logic eer);
    check({req, " valid"}, 16'(out_valid), 16'd1);
    check({req, " pc"}, out_pc, epc);
    check({req, " taken"}, 16'(out_taken), 16'(etk));
    check({req, " err"}, 16'(out_err), 16'(eer));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R11 ready in reset", 16'(in_ready), 16'd0);
    check("R11 valid in reset", 16'(out_valid), 16'd0);
    check("R11 link in reset", out_link, 16'h0000);
    check("R11 pc in reset", out_pc, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R11 ready after reset", 16'(in_ready), 16'd1);

    for (int i = 0; i < NVEC; i++) begin
      issue(TBL[i].op, TBL[i].dly, TBL[i].ureg, TBL[i].cond, TBL[i].disp,
            TBL[i].flg, TBL[i].pc, TBL[i].rg);
      result($sformatf("vec%0d R1-table", i), TBL[i].epc, TBL[i].etk, TBL[i].eer);
    end

    // R6 / R7: plain call then return
    issue(3'd4, 1'b0, 1'b0, 4'd0, 10'h008, 4'h0, 16'h1000, 16'h0);
    result("R6 call", 16'h1012, 1'b1, 1'b0);
    check("R6 link plain", out_link, 16'h1002);
    issue(3'd6, 1'b0, 1'b0, 4'd0, 10'h000, 4'h0, 16'h1012, 16'h0);
    result("R7 ret", 16'h1002, 1'b1, 1'b0);

    // R6 / R8: delayed absolute call through register
    issue(3'd5, 1'b1, 1'b1, 4'd0, 10'h000, 4'h0, 16'h1100, 16'h2000);
    result("R8 dcall slot", 16'h1102, 1'b0, 1'b0);
    check("R6 link delayed", out_link, 16'h1104);
    issue(3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'h0, 16'h1102, 16'h0);
    result("R8 dcall transfer", 16'h2000, 1'b1, 1'b0);

    // R7 / R8 / R10: delayed return with an idle gap before the slot
    issue(3'd6, 1'b1, 1'b0, 4'd0, 10'h000, 4'h0, 16'h2000, 16'h0);
    result("R7 dret slot", 16'h2002, 1'b0, 1'b0);
    idle();
    check("R10 idle no result", 16'(out_valid), 16'd0);
    issue(3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'h0, 16'h2002, 16'h0);
    result("R10 pending kept", 16'h1104, 1'b1, 1'b0);

    // R9: call in a slot leaves link untouched
    issue(3'd1, 1'b1, 1'b0, 4'd0, 10'h001, 4'h0, 16'h3000, 16'h0);
    result("R9 delayed jump", 16'h3002, 1'b0, 1'b0);
    issue(3'd4, 1'b0, 1'b0, 4'd0, 10'h040, 4'h0, 16'h3002, 16'h0);
    result("R9 call in slot", 16'h3004, 1'b1, 1'b1);
    check("R9 link kept", out_link, 16'h1104);

    // R11: reset clears a pending delay
    issue(3'd1, 1'b1, 1'b0, 4'd0, 10'h010, 4'h0, 16'h4000, 16'h0);
    result("R11 delayed before reset", 16'h4002, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R11 link cleared", out_link, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    issue(3'd0, 1'b0, 1'b0, 4'd0, 10'h000, 4'h0, 16'h4002, 16'h0);
    result("R11 no pending after reset", 16'h4004, 1'b0, 1'b0);

    idle();
    finish_run();
  end
endmodule